// File: doc/BRIEF.md
# Interval Interrupt Timer and Status Register Controller

This block holds the control and status logic of a bus-attached real-time clock and a programmable interval interrupt timer. A host processor reaches it through a small asynchronous bus: chip select, read and write strobes, a 4-bit address and 4-bit data. The block samples that bus on a fast system clock. Address 0 is split. A write sets four control latches: test, clock halt, interrupt-register select and interrupt stop. A read returns the data-changed flag and the interrupt flag. Address 15 reaches the internal interrupt register when the select latch is set. In every other case the access is passed to the time-counter logic through the `ext_*` ports.

The interval timer counts a one-cycle 10 Hz setting strobe (`tick`) against a delay picked by a 3-bit code. It can stop after one timeout or repeat on a fixed tick grid. A timeout raises the interrupt flag and pulls `int_n` low. A control-register read clears both flags at the end of its strobe. A timeout that lands during that read is held back until the read ends. A setting strobe that lands during that read is dropped.

The design has two state machines. The bus tracker has three states: `BUS_IDLE`, `BUS_RD` and `BUS_WR`. Its transitions are:
- IDLE to WR when the write strobe opens.
- IDLE to RD when only the read strobe opens.
- RD to IDLE when the read strobe closes. This is the read-end event.
- WR to IDLE when the write strobe closes. This is the commit event.

The timer has three states: `TMR_STOPPED`, `TMR_RUN` and `TMR_EXPIRED`. Its transitions are:
- Any state to STOPPED on a stop request.
- STOPPED or EXPIRED to RUN on a start request.
- RUN to RUN with the count cleared on a timeout in repeat mode.
- RUN to EXPIRED on a timeout in single mode.

Top module: `rtc_ctl_top`

## Requirements
- R1: After reset the following hold. A control read returns 0000. `int_n` is 1 and `clk_halt` is 0. The interrupt register reads 0000. The interrupt-stop latch is 1.
- R2: A write to address 0 takes effect when its strobe (CS and WR both low) closes. Bit 2 of the written value appears on `clk_halt`.
- R3: When control bit 1 is 1, address 15 reads and writes the interrupt register. Its bits 2:0 are the delay code and bit 3 is the mode (0 single, 1 repeat). When control bit 1 is 0, address 15 reads `ext_rdata`. All addresses other than 0 and the selected interrupt register always go to the `ext_*` ports.
- R4: The data-changed flag is read at bit 3 of address 0. A `tick` sets it. Only a control read clears it. Writes and reads of other addresses leave it unchanged. A `tick` during a control read does not set it.
- R5: Storing a new delay code does not start timing. Timing starts only when 0 is written to control bit 0.
- R6: The delay is counted in ticks. Codes 1 to 7 give 1, 5, 10, 50, 100, 300 and 600 ticks. A timeout sets the interrupt flag (read bit 0) and drives `int_n` low.
- R7: A control read returns {dcf,0,0,iflag}. The value is frozen for the whole read strobe. Both flags clear when the read strobe closes, and `int_n` returns to 1.
- R8: A timeout during a control read leaves `int_n` and the read value unchanged. The flag is raised after the read ends.
- R9: In single mode the timer halts after one timeout. Writing 0 to control bit 0 starts a new full delay.
- R10: In repeat mode timeouts fall every N ticks on the grid set by the first start. Further writes of 0 to control bit 0 do not shift that grid.
- R11: Writing 1 to control bit 0 resets the timer. The next start gives a full delay.
- R12: Writing delay code 000 clears the interrupt flag and `int_n`, and forces the interrupt-stop latch to 1. Timing then does not resume until a new code is stored and 0 is written to control bit 0.
- R13: With control bit 3 set, `int_n` follows `osc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Register address |
| wdata | input | 4 | Write data |
| tick | input | 1 | One-cycle 10 Hz setting strobe |
| osc | input | 1 | Crystal clock level, used in test mode |
| ext_rdata | input | 4 | Read data from the time counters |
| rdata | output | 4 | Read data to the bus |
| ext_we | output | 1 | One-cycle write commit to the time counters |
| ext_addr | output | ADDR_W | Address of the committed external write |
| ext_wdata | output | 4 | Data of the committed external write |
| clk_halt | output | 1 | Clock-halt latch |
| int_n | output | 1 | Interrupt output, active low |

## Verification
Two events can fall in the same cycle: a timer timeout or a setting strobe, and an open control-register read. The bench provokes this by pulsing `tick` while CS and RD are held low at address 0. It does so both in directed cases and at random points of a repeat-mode run. For each case a reference model predicts three things: the frozen read value, an unchanged `int_n` while the strobe is open, and the deferred interrupt flag with no data-changed flag once the read closes.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_WR   = 2'd2
    } bus_state_t;

    typedef enum logic [1:0] {
        TMR_STOPPED = 2'd0,
        TMR_RUN     = 2'd1,
        TMR_EXPIRED = 2'd2
    } tmr_state_t;

    typedef struct packed {
        logic test;
        logic clk_stop;
        logic irq_sel;
        logic irq_stop;
    } ctl_bits_t;

    // Delay length in tenths of a second for each code; 0 means no timer.
    function automatic int unsigned delay_tenths(input logic [2:0] code);
        case (code)
            3'd1:    delay_tenths = 1;
            3'd2:    delay_tenths = 5;
            3'd3:    delay_tenths = 10;
            3'd4:    delay_tenths = 50;
            3'd5:    delay_tenths = 100;
            3'd6:    delay_tenths = 300;
            3'd7:    delay_tenths = 600;
            default: delay_tenths = 0;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_ctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bus_state_t        state_o,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data,
    output logic              rd_begin,
    output logic              rd_end,
    output logic              wr_end
);

    logic       rs, ws;
    bus_state_t state_q, state_d;

    assign rs = !cs_n && !rd_n;
    assign ws = !cs_n && !wr_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (ws)      state_d = BUS_WR;
                else if (rs) state_d = BUS_RD;
            end
            BUS_RD:  if (!rs) state_d = BUS_IDLE;
            BUS_WR:  if (!ws) state_d = BUS_IDLE;
            default: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Address and data track the bus while the strobe is open, so the
    // values present at the closing edge are the ones committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
        end else begin
            if ((state_q == BUS_IDLE && (rs || ws)) ||
                (state_q == BUS_RD && rs) ||
                (state_q == BUS_WR && ws))
                hold_addr <= addr;
            if (ws && state_q != BUS_RD)
                hold_data <= wdata;
        end
    end

    always_comb begin
        state_o  = state_q;
        rd_begin = (state_q == BUS_IDLE) && rs && !ws;
        rd_end   = (state_q == BUS_RD) && !rs;
        wr_end   = (state_q == BUS_WR) && !ws;
    end

endmodule

// File: rtl/rtc_irq_timer.sv
module rtc_irq_timer
    import rtc_ctl_pkg::*;
#(
    parameter int TICK_HZ = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       stop,
    input  logic [2:0] code,
    input  logic       repeat_en,
    output logic       timeout,
    output tmr_state_t state_o
);

    localparam int CW = $clog2(60 * TICK_HZ + 1);

    tmr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim;
    logic          hit;

    always_comb begin
        lim = CW'(delay_tenths(code) * TICK_HZ / 10);
        hit = tick && (lim != '0) && (cnt_q == lim - 1'b1);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (stop) begin
            state_d = TMR_STOPPED;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_STOPPED, TMR_EXPIRED: begin
                    if (start) begin
                        state_d = TMR_RUN;
                        cnt_d   = '0;
                    end
                end
                TMR_RUN: begin
                    if (hit) begin
                        cnt_d   = '0;
                        state_d = repeat_en ? TMR_RUN : TMR_EXPIRED;
                    end else if (tick) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = TMR_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_STOPPED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_o = state_q;
        timeout = (state_q == TMR_RUN) && hit && !stop;
    end

endmodule

// File: rtl/rtc_status.sv
module rtc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       timeout,
    input  logic       in_ctl_rd,
    input  logic       ctl_rd_end,
    input  logic       snap_take,
    input  logic       clr_irq,
    output logic       dcf,
    output logic       iflag,
    output logic [3:0] snap
);

    logic pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcf   <= 1'b0;
            iflag <= 1'b0;
            pend  <= 1'b0;
        end else if (ctl_rd_end) begin
            dcf   <= 1'b0;
            iflag <= pend || timeout;
            pend  <= 1'b0;
        end else begin
            if (tick && !in_ctl_rd) dcf <= 1'b1;
            if (clr_irq) begin
                iflag <= 1'b0;
                pend  <= 1'b0;
            end else if (timeout) begin
                if (in_ctl_rd) pend  <= 1'b1;
                else           iflag <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         snap <= '0;
        else if (snap_take) snap <= {dcf, 2'b00, iflag};
    end

endmodule

// File: rtl/rtc_ctl_top.sv
module rtc_ctl_top
    import rtc_ctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int TICK_HZ = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        wdata,
    input  logic              tick,
    input  logic              osc,
    input  logic [3:0]        ext_rdata,
    output logic [3:0]        rdata,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [3:0]        ext_wdata,
    output logic              clk_halt,
    output logic              int_n
);

    localparam int                DATA_W   = 4;
    localparam logic [ADDR_W-1:0] CTL_ADDR = '0;
    localparam logic [ADDR_W-1:0] SEL_ADDR = '1;

    bus_state_t        bus_st;
    tmr_state_t        tmr_st;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic              rd_begin, rd_end, wr_end;
    ctl_bits_t         ctl_q;
    logic [3:0]        ireg_q;
    logic              wr_ctl, wr_ireg, in_ctl_rd, ctl_rd_end;
    logic              t_start, t_stop, timeout;
    logic              dcf, iflag;
    logic [3:0]        snap;

    rtc_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .state_o(bus_st),
        .hold_addr(hold_addr), .hold_data(hold_data),
        .rd_begin(rd_begin), .rd_end(rd_end), .wr_end(wr_end)
    );

    always_comb begin
        wr_ctl     = wr_end && (hold_addr == CTL_ADDR);
        wr_ireg    = wr_end && (hold_addr == SEL_ADDR) && ctl_q.irq_sel;
        in_ctl_rd  = ((bus_st == BUS_RD) && (hold_addr == CTL_ADDR)) ||
                     (rd_begin && (addr == CTL_ADDR));
        ctl_rd_end = rd_end && (hold_addr == CTL_ADDR);
        t_start    = wr_ctl && !hold_data[0] && (ireg_q[2:0] != 3'd0);
        t_stop     = (wr_ctl && hold_data[0]) ||
                     (wr_ireg && (hold_data[2:0] == 3'd0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '{test: 1'b0, clk_stop: 1'b0, irq_sel: 1'b0, irq_stop: 1'b1};
            ireg_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= '{test:     hold_data[3],
                       clk_stop: hold_data[2],
                       irq_sel:  hold_data[1],
                       irq_stop: hold_data[0] || (ireg_q[2:0] == 3'd0)};
        end else if (wr_ireg) begin
            ireg_q <= hold_data;
            if (hold_data[2:0] == 3'd0) ctl_q.irq_stop <= 1'b1;
        end
    end

    rtc_irq_timer #(.TICK_HZ(TICK_HZ)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(t_start), .stop(t_stop),
        .code(ireg_q[2:0]), .repeat_en(ireg_q[3]),
        .timeout(timeout), .state_o(tmr_st)
    );

    rtc_status u_stat (
        .clk(clk), .rst_n(rst_n), .tick(tick), .timeout(timeout),
        .in_ctl_rd(in_ctl_rd), .ctl_rd_end(ctl_rd_end),
        .snap_take(rd_begin && (addr == CTL_ADDR)),
        .clr_irq(wr_ireg && (hold_data[2:0] == 3'd0)),
        .dcf(dcf), .iflag(iflag), .snap(snap)
    );

    always_comb begin
        if (addr == CTL_ADDR)
            rdata = (bus_st == BUS_RD) ? snap : {dcf, 2'b00, iflag};
        else if ((addr == SEL_ADDR) && ctl_q.irq_sel)
            rdata = ireg_q;
        else
            rdata = ext_rdata;
        ext_we    = wr_end && (hold_addr != CTL_ADDR) && !wr_ireg;
        ext_addr  = hold_addr;
        ext_wdata = hold_data;
        clk_halt  = ctl_q.clk_stop;
        int_n     = ctl_q.test ? osc : !iflag;
    end

endmodule

// File: rtl/rtc_ctl_chk.sv
module rtc_ctl_chk
    import rtc_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_t        bus_st,
    input tmr_state_t        tmr_st,
    input logic [ADDR_W-1:0] hold_addr,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        rdata,
    input logic              int_n,
    input logic              test,
    input logic              irq_stop,
    input logic [3:0]        ireg,
    input logic              timeout,
    input logic              tick,
    input logic              in_ctl_rd,
    input logic              dcf
);

    logic in_rd0;
    assign in_rd0 = (bus_st == BUS_RD) && (hold_addr == '0) && (addr == '0);

    p_rdata_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd0 && $past(in_rd0) |-> $stable(rdata));

    p_int_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st == BUS_RD) && (hold_addr == '0) && $past(bus_st == BUS_RD) &&
        $past(hold_addr == '0) && !test && $past(!test) |-> $stable(int_n));

    p_stop_not_running_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stop |-> tmr_st != TMR_RUN);

    p_code0_forces_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ireg[2:0] == 3'd0 |-> irq_stop);

    p_single_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout && !ireg[3] |=> tmr_st == TMR_EXPIRED);

    p_dcf_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dcf) |-> $past(tick) && !$past(in_ctl_rd));

endmodule

bind rtc_ctl_top rtc_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_st(bus_st), .tmr_st(tmr_st),
    .hold_addr(hold_addr), .addr(addr), .rdata(rdata), .int_n(int_n),
    .test(ctl_q.test), .irq_stop(ctl_q.irq_stop), .ireg(ireg_q),
    .timeout(timeout), .tick(tick), .in_ctl_rd(in_ctl_rd), .dcf(dcf)
);

// File: tb/rtc_ctl_top_tb.sv
module rtc_ctl_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] addr = '0, wdata = '0;
    logic       tick = 1'b0, osc = 1'b0;
    logic [3:0] ext_rdata = 4'hA;
    logic [3:0] rdata, ext_wdata, ext_addr;
    logic       ext_we, clk_halt, int_n;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // 200 MHz: 5 ns period
    always #2.5 clk = ~clk;

    rtc_ctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .tick(tick), .osc(osc),
        .ext_rdata(ext_rdata), .rdata(rdata), .ext_we(ext_we),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .clk_halt(clk_halt), .int_n(int_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int ticks_for(input logic [2:0] code);
        case (code)
            3'd1: return 1;
            3'd2: return 5;
            3'd3: return 10;
            3'd4: return 50;
            3'd5: return 100;
            3'd6: return 300;
            3'd7: return 600;
            default: return 0;
        endcase
    endfunction

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk); addr = a; wdata = d; cs_n = 0; wr_n = 0;
        @(negedge clk); cs_n = 1; wr_n = 1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] v);
        @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
        @(negedge clk); v = rdata; cs_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic rd_tick(output logic [3:0] v, output logic im);
        @(negedge clk); addr = 4'd0; cs_n = 0; rd_n = 0;
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0; v = rdata; im = int_n; cs_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    logic [3:0] v;
    logic       im;
    int unsigned seed_init;

    initial begin
        seed_init = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 int_n", {3'b0, int_n}, 4'h1);
        check("R1 clk_halt", {3'b0, clk_halt}, 4'h0);
        rd(4'd0, v); check("R1 ctl read", v, 4'h0);
        wr(4'd0, 4'b0010);
        rd(4'd15, v); check("R1 ireg reset", v, 4'h0);

        // R2 control write commit
        wr(4'd0, 4'b0111); check("R2 halt set", {3'b0, clk_halt}, 4'h1);
        wr(4'd0, 4'b0011); check("R2 halt clr", {3'b0, clk_halt}, 4'h0);

        // R3 address 15 mapping
        wr(4'd15, 4'b1001);
        rd(4'd15, v); check("R3 ireg readback", v, 4'h9);
        wr(4'd0, 4'b0001);
        rd(4'd15, v); check("R3 ext at 15", v, 4'hA);
        rd(4'd5, v); check("R3 ext at 5", v, 4'hA);

        // R5 stored code does not start
        wr(4'd0, 4'b0011);
        ticks(3); check("R5 no start", {3'b0, int_n}, 4'h1);

        // R6 1-tick delay times out
        wr(4'd0, 4'b0010);
        ticks(1); check("R6 timeout int_n", {3'b0, int_n}, 4'h0);

        // R7 read clears flags
        rd(4'd0, v); check("R7 status", v, 4'h9);
        check("R7 int_n clr", {3'b0, int_n}, 4'h1);
        rd(4'd0, v); check("R7 cleared", v, 4'h0);

        // R4 writes/other reads leave dcf
        ticks(1);
        wr(4'd2, 4'h5); rd(4'd2, v);
        rd(4'd0, v); check("R4 dcf kept", v, 4'h9);

        // R8 timeout during control read deferred; R4 tick ignored
        rd_tick(v, im);
        check("R8 read value", v, 4'h0);
        check("R8 int_n held", {3'b0, im}, 4'h1);
        check("R8 int_n after", {3'b0, int_n}, 4'h0);
        rd(4'd0, v); check("R4 R8 after read", v, 4'h1);

        // R9 single mode, 5 ticks
        wr(4'd0, 4'b0011); wr(4'd15, 4'b0010); wr(4'd0, 4'b0010);
        ticks(4); check("R6 before 5", {3'b0, int_n}, 4'h1);
        ticks(1); check("R6 at 5", {3'b0, int_n}, 4'h0);
        rd(4'd0, v);
        ticks(10); check("R9 halted", {3'b0, int_n}, 4'h1);
        wr(4'd0, 4'b0010);
        ticks(4); check("R9 restart early", {3'b0, int_n}, 4'h1);
        ticks(1); check("R9 restart full", {3'b0, int_n}, 4'h0);
        rd(4'd0, v);

        // R11 stop resets the count
        wr(4'd0, 4'b0011); wr(4'd15, 4'b1010); wr(4'd0, 4'b0010);
        ticks(3);
        wr(4'd0, 4'b0011); wr(4'd0, 4'b0010);
        ticks(4); check("R11 full period", {3'b0, int_n}, 4'h1);
        ticks(1); check("R11 timeout", {3'b0, int_n}, 4'h0);
        rd(4'd0, v);

        // R12 code 000 clears and stops
        ticks(5); check("R12 pre", {3'b0, int_n}, 4'h0);
        wr(4'd15, 4'b0000); check("R12 int cleared", {3'b0, int_n}, 4'h1);
        wr(4'd15, 4'b1001);
        ticks(3); check("R12 stays stopped", {3'b0, int_n}, 4'h1);
        rd(4'd0, v); check("R12 no flag", v, 4'h8);

        // R13 test mode
        wr(4'd0, 4'b1011);
        @(negedge clk); osc = 1;
        @(negedge clk); check("R13 osc hi", {3'b0, int_n}, 4'h1);
        osc = 0;
        @(negedge clk); check("R13 osc lo", {3'b0, int_n}, 4'h0);
        wr(4'd0, 4'b0011);

        // Random repeat-mode run (R10) with overlapping reads (R4, R7, R8)
        for (int run = 0; run < 3; run++) begin
            logic [2:0] code;
            int lim, cnt;
            logic m_dcf, m_if;
            code = 3'($urandom_range(1, 3));
            lim = ticks_for(code);
            wr(4'd0, 4'b0011);
            wr(4'd15, {1'b1, code});
            rd(4'd0, v);
            wr(4'd0, 4'b0000);
            cnt = 0; m_dcf = 0; m_if = 0;
            for (int it = 0; it < 150; it++) begin
                int op;
                op = $urandom_range(0, 4);
                case (op)
                    0: begin
                        ticks(1);
                        m_dcf = 1; cnt++;
                        if (cnt == lim) begin cnt = 0; m_if = 1; end
                        check("R10 int_n", {3'b0, int_n}, {3'b0, !m_if});
                    end
                    1: begin
                        rd(4'd0, v);
                        check("R7 status", v, {m_dcf, 2'b00, m_if});
                        m_dcf = 0; m_if = 0;
                    end
                    2: begin
                        logic pend;
                        rd_tick(v, im);
                        check("R8 frozen", v, {m_dcf, 2'b00, m_if});
                        check("R8 int held", {3'b0, im}, {3'b0, !m_if});
                        pend = 0; cnt++;
                        if (cnt == lim) begin cnt = 0; pend = 1; end
                        m_dcf = 0; m_if = pend;
                        check("R8 int after", {3'b0, int_n}, {3'b0, !m_if});
                    end
                    3: begin
                        wr(4'd3, 4'($urandom_range(0, 15)));
                        rd(4'd4, v);
                        check("R4 ext read", v, 4'hA);
                    end
                    default: begin
                        wr(4'd0, 4'b0000);
                        check("R10 no rephase", {3'b0, int_n}, {3'b0, !m_if});
                    end
                endcase
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule